// File: doc/BRIEF.md
# Global Timer with Self-Advancing Compare

This block is a 64-bit free-running time base with one 64-bit compare channel, seen by software through a word-addressed register port with 32-bit data. The counter runs one step per clock while the timer is started. Software can read or overwrite either 32-bit half of the count. The compare channel flags a match when the count equals the compare value. In periodic mode it then moves its own compare value forward by a programmed step, so matches recur at a fixed spacing.

Writes to the six timing registers (both count halves, both compare halves, the step and the control word) are confirmed a clock later by a per-register "accepted" flag. The count halves report in one status word. The other four report in a second status word. Software clears these flags by writing ones. A match sets a sticky pending bit. While interrupts are enabled, the rising edge of that bit produces a single-cycle pulse on the interrupt output.

Register map (word addresses): 0 count low, 1 count high, 2 count-accept flags, 3 compare low, 4 compare high, 5 step, 6 control, 7 interrupt enable, 8 pending status, 9 timing-accept flags. Addresses 10 to 15 read as zero and ignore writes.

Top module: `gtimer_top`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: While control bit 0 (run) is 1, the count rises by one on every clock edge and wraps from all-ones to zero. While that bit is 0, the count holds.
- R3: A write to address 0 replaces only count bits 31:0, and a write to address 1 replaces only bits 63:32. The count does not advance on the edge that takes the write.
- R4: Address 2 bit 0 (low half) or bit 1 (high half) becomes 1 on the clock edge after the one that stores a write to that count half.
- R5: Address 9 gets bit 0 for a compare-low write, bit 1 for compare-high, bit 2 for step and bit 3 for control. Each bit becomes 1 on the clock edge after the one that stores the write.
- R6: Writing to address 2 or 9 clears each flag whose data bit is 1 and leaves the others alone. A flag setting on the same edge wins over a clear. Writes to addresses 7 and 8, to the flag words themselves, or to unmapped addresses set no flag.
- R7: While control bit 1 (compare enable) is 1 and the count equals the compare value, pending (address 8 bit 0) is 1 from the next edge. With control bit 2 at 0, the compare value is left unchanged.
- R8: With control bit 2 (periodic) at 1, each match adds the 32-bit step (address 5) to the 64-bit compare value, modulo 2^64.
- R9: `irq` is high for exactly one cycle, in the first cycle that pending reads 1 after reading 0, and only if address 7 bit 0 is 1. Otherwise `irq` stays low.
- R10: Pending stays 1, whatever the enable, until a write to address 8 with data bit 0 set. A match on the same edge wins over that clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one register per cycle |
| wr_addr | input | 4 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Word address of the read |
| rd_data | output | 32 | Read data, combinational from register state |
| irq | output | 1 | Single-cycle interrupt pulse |

## Verification
The bench sets the count just below the 2^64 boundary. A design that carries badly between the halves, or that overwrites both halves on a single write, then shows a wrong high word. It reads the accept flags in the cycle the flag is due and in the cycle before. It clears flags one bit at a time, so a flag that sets early, sets late, or is cleared by a zero data bit shows a mismatch. It also triggers matches with the interrupt enable off and shows that pending stays while `irq` stays quiet. In periodic mode it clears pending on every cycle, so a lost set-over-clear priority, or a compare that fails to advance by the step, changes the pulse train the model predicts.

// File: rtl/gtimer_pkg.sv
package gtimer_pkg;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 2 * DATA_W;
  localparam int NREG    = 2 ** ADDR_W;
  localparam int CWS_W   = 2;
  localparam int GWS_W   = 4;
  localparam int CTRL_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CNT_LO = 4'd0,
    A_CNT_HI = 4'd1,
    A_CNT_WS = 4'd2,
    A_CMP_LO = 4'd3,
    A_CMP_HI = 4'd4,
    A_STEP   = 4'd5,
    A_CTRL   = 4'd6,
    A_IEN    = 4'd7,
    A_ISTAT  = 4'd8,
    A_GEN_WS = 4'd9
  } reg_e;

  localparam int CTL_RUN  = 0;
  localparam int CTL_CEN  = 1;
  localparam int CTL_AUTO = 2;

  // Replace one 32-bit half of a 64-bit word.
  function automatic logic [CNT_W-1:0] put_half(input logic [CNT_W-1:0] cur,
                                                input logic [DATA_W-1:0] val,
                                                input logic upper);
    put_half = upper ? {val, cur[DATA_W-1:0]} : {cur[CNT_W-1:DATA_W], val};
  endfunction

  // Periodic advance of the compare value by the step, modulo 2^64.
  function automatic logic [CNT_W-1:0] cmp_advance(input logic [CNT_W-1:0] cmp,
                                                   input logic [DATA_W-1:0] step);
    cmp_advance = cmp + {{(CNT_W-DATA_W){1'b0}}, step};
  endfunction
endpackage

// File: rtl/gtimer_counter.sv
module gtimer_counter
  import gtimer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt,
  output logic              tick
);
  assign tick = run && !wr_lo && !wr_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (wr_lo) cnt <= put_half(cnt, wdata, 1'b0);
    else if (wr_hi) cnt <= put_half(cnt, wdata, 1'b1);
    else if (tick)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/gtimer_cmp.sv
module gtimer_cmp
  import gtimer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_step,
  input  logic [DATA_W-1:0] wdata,
  input  logic              en,
  input  logic              auto_mode,
  input  logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  cmp,
  output logic [DATA_W-1:0] step,
  output logic              match,
  output logic              advance
);
  assign match   = en && (cnt == cmp);
  assign advance = match && auto_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cmp <= '0;
    else if (wr_lo)   cmp <= put_half(cmp, wdata, 1'b0);
    else if (wr_hi)   cmp <= put_half(cmp, wdata, 1'b1);
    else if (advance) cmp <= cmp_advance(cmp, step);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step <= '0;
    else if (wr_step) step <= wdata;
  end
endmodule

// File: rtl/gtimer_wack.sv
module gtimer_wack #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_req,
  input  logic         clr_wr,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] flags
);
  logic [W-1:0] arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= '0;
    else        arm_q <= set_req;
  end

  for (genvar i = 0; i < W; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      flags[i] <= 1'b0;
      else if (arm_q[i])               flags[i] <= 1'b1;
      else if (clr_wr && clr_bits[i])  flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/gtimer_irq.sv
module gtimer_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic clr,
  input  logic ien,
  output logic pend,
  output logic irq
);
  logic pend_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      pend_d <= 1'b0;
    end else begin
      pend   <= match || (pend && !clr);
      pend_d <= pend;
    end
  end

  assign irq = pend && !pend_d && ien;
endmodule

// File: rtl/gtimer_top.sv
module gtimer_top
  import gtimer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic [NREG-1:0]   wsel;
  logic              cnt_wr_lo, cnt_wr_hi, cmp_wr_lo, cmp_wr_hi;
  logic              step_wr, ctrl_wr, ien_wr, istat_clr;
  logic              cws_wr, gws_wr, cnt_wr, cmp_wr;
  logic [CTRL_W-1:0] ctrl_q;
  logic              ien_q;
  logic              run, cen, auto_mode;
  logic [CNT_W-1:0]  cnt, cmp;
  logic [DATA_W-1:0] step;
  logic              tick, match, advance, pend;
  logic [CWS_W-1:0]  cws, cws_set;
  logic [GWS_W-1:0]  gws, gws_set;

  assign wsel      = wr_en ? (NREG'(1) << wr_addr) : '0;
  assign cnt_wr_lo = wsel[A_CNT_LO];
  assign cnt_wr_hi = wsel[A_CNT_HI];
  assign cmp_wr_lo = wsel[A_CMP_LO];
  assign cmp_wr_hi = wsel[A_CMP_HI];
  assign step_wr   = wsel[A_STEP];
  assign ctrl_wr   = wsel[A_CTRL];
  assign ien_wr    = wsel[A_IEN];
  assign istat_clr = wsel[A_ISTAT] && wr_data[0];
  assign cws_wr    = wsel[A_CNT_WS];
  assign gws_wr    = wsel[A_GEN_WS];
  assign cnt_wr    = cnt_wr_lo || cnt_wr_hi;
  assign cmp_wr    = cmp_wr_lo || cmp_wr_hi;

  assign cws_set = {cnt_wr_hi, cnt_wr_lo};
  assign gws_set = {ctrl_wr, step_wr, cmp_wr_hi, cmp_wr_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q  <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= wr_data[CTRL_W-1:0];
      if (ien_wr)  ien_q  <= wr_data[0];
    end
  end

  assign run       = ctrl_q[CTL_RUN];
  assign cen       = ctrl_q[CTL_CEN];
  assign auto_mode = ctrl_q[CTL_AUTO];

  gtimer_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .wr_lo(cnt_wr_lo), .wr_hi(cnt_wr_hi),
    .wdata(wr_data), .cnt(cnt), .tick(tick)
  );

  gtimer_cmp u_cmp (
    .clk(clk), .rst_n(rst_n), .wr_lo(cmp_wr_lo), .wr_hi(cmp_wr_hi),
    .wr_step(step_wr), .wdata(wr_data), .en(cen), .auto_mode(auto_mode),
    .cnt(cnt), .cmp(cmp), .step(step), .match(match), .advance(advance)
  );

  gtimer_wack #(.W(CWS_W)) u_cws (
    .clk(clk), .rst_n(rst_n), .set_req(cws_set), .clr_wr(cws_wr),
    .clr_bits(wr_data[CWS_W-1:0]), .flags(cws)
  );

  gtimer_wack #(.W(GWS_W)) u_gws (
    .clk(clk), .rst_n(rst_n), .set_req(gws_set), .clr_wr(gws_wr),
    .clr_bits(wr_data[GWS_W-1:0]), .flags(gws)
  );

  gtimer_irq u_irq (
    .clk(clk), .rst_n(rst_n), .match(match), .clr(istat_clr), .ien(ien_q),
    .pend(pend), .irq(irq)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CNT_LO: rd_data = cnt[DATA_W-1:0];
      A_CNT_HI: rd_data = cnt[CNT_W-1:DATA_W];
      A_CNT_WS: rd_data = DATA_W'(cws);
      A_CMP_LO: rd_data = cmp[DATA_W-1:0];
      A_CMP_HI: rd_data = cmp[CNT_W-1:DATA_W];
      A_STEP:   rd_data = step;
      A_CTRL:   rd_data = DATA_W'(ctrl_q);
      A_IEN:    rd_data = DATA_W'(ien_q);
      A_ISTAT:  rd_data = DATA_W'(pend);
      A_GEN_WS: rd_data = DATA_W'(gws);
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/gtimer_chk.sv
module gtimer_chk
  import gtimer_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              run,
  input logic              cnt_wr,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cmp,
  input logic [DATA_W-1:0] step,
  input logic              cmp_wr,
  input logic              cnt_wr_lo,
  input logic              ctrl_wr,
  input logic [CWS_W-1:0]  cws,
  input logic [GWS_W-1:0]  gws,
  input logic              match,
  input logic              auto_mode,
  input logic              advance,
  input logic              pend,
  input logic              istat_clr,
  input logic              ien_q,
  input logic              irq
);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == $past(cnt) + 1'b1);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt));
  // R4
  cws_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_lo |-> ##2 cws[0]);
  // R5
  gws_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |-> ##2 gws[3]);
  // R7
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> pend);
  // R7
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !auto_mode && !cmp_wr) |=> $stable(cmp));
  // R8
  auto_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !cmp_wr) |=> cmp == $past(cmp) + {32'd0, $past(step)});
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien_q && pend));
  // R9
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R10
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !istat_clr) |=> pend);
endmodule

bind gtimer_top gtimer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .cnt_wr(cnt_wr),
  .cnt(cnt), .cmp(cmp), .step(step), .cmp_wr(cmp_wr), .cnt_wr_lo(cnt_wr_lo),
  .ctrl_wr(ctrl_wr), .cws(cws), .gws(gws), .match(match),
  .auto_mode(auto_mode), .advance(advance), .pend(pend),
  .istat_clr(istat_clr), .ien_q(ien_q), .irq(irq)
);

// File: tb/gtimer_top_tb_top.sv
module gtimer_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  gtimer_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  always #10 clk = ~clk;

  // Behavioural reference state
  bit [63:0] m_cnt, m_cmp;
  bit [31:0] m_step;
  bit [2:0]  m_ctrl;
  bit        m_ien, m_pend, m_pend_old;
  bit [1:0]  m_cws, m_cws_arm;
  bit [3:0]  m_gws, m_gws_arm;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 0; m_step = 0; m_ctrl = 0; m_ien = 0;
      m_pend = 0; m_pend_old = 0; m_cws = 0; m_cws_arm = 0;
      m_gws = 0; m_gws_arm = 0;
    end else begin
      bit hit;
      bit [63:0] n_cnt, n_cmp;
      bit [1:0] n_carm;
      bit [3:0] n_garm;
      hit = m_ctrl[1] && (m_cnt == m_cmp);
      n_cnt = m_cnt;
      if (wr_en && wr_addr == 0)      n_cnt[31:0]  = wr_data;
      else if (wr_en && wr_addr == 1) n_cnt[63:32] = wr_data;
      else if (m_ctrl[0])             n_cnt = m_cnt + 64'd1;
      n_cmp = m_cmp;
      if (wr_en && wr_addr == 3)      n_cmp[31:0]  = wr_data;
      else if (wr_en && wr_addr == 4) n_cmp[63:32] = wr_data;
      else if (hit && m_ctrl[2])      n_cmp = m_cmp + {32'd0, m_step};
      n_carm = 0; n_garm = 0;
      if (wr_en) begin
        case (wr_addr)
          4'd0: n_carm[0] = 1;
          4'd1: n_carm[1] = 1;
          4'd3: n_garm[0] = 1;
          4'd4: n_garm[1] = 1;
          4'd5: n_garm[2] = 1;
          4'd6: n_garm[3] = 1;
          default: ;
        endcase
      end
      if (wr_en && wr_addr == 2) m_cws = m_cws & ~wr_data[1:0];
      m_cws = m_cws | m_cws_arm;
      if (wr_en && wr_addr == 9) m_gws = m_gws & ~wr_data[3:0];
      m_gws = m_gws | m_gws_arm;
      m_cws_arm = n_carm; m_gws_arm = n_garm;
      if (wr_en && wr_addr == 5) m_step = wr_data;
      if (wr_en && wr_addr == 6) m_ctrl = wr_data[2:0];
      if (wr_en && wr_addr == 7) m_ien = wr_data[0];
      m_pend_old = m_pend;
      m_pend = hit || (m_pend && !(wr_en && wr_addr == 8 && wr_data[0]));
      m_cnt = n_cnt; m_cmp = n_cmp;
    end
  end

  function automatic bit [31:0] m_read(input bit [3:0] a);
    case (a)
      4'd0: return m_cnt[31:0];
      4'd1: return m_cnt[63:32];
      4'd2: return {30'd0, m_cws};
      4'd3: return m_cmp[31:0];
      4'd4: return m_cmp[63:32];
      4'd5: return m_step;
      4'd6: return {29'd0, m_ctrl};
      4'd7: return {31'd0, m_ien};
      4'd8: return {31'd0, m_pend};
      4'd9: return {28'd0, m_gws};
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input bit [31:0] act, input bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // R9: irq compared with the model every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      #2;
      check("R9 irq", {31'd0, irq}, {31'd0, m_pend && !m_pend_old && m_ien});
    end
  end

  task automatic wr(input bit [3:0] a, input bit [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 0;
  endtask

  task automatic rd(input string tag, input bit [3:0] a);
    @(negedge clk);
    rd_addr = a;
    #1 check(tag, rd_data, m_read(a));
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      done = 1;
      summary();
    end
  end

  initial begin
    bit [31:0] lo;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset values
    for (int a = 0; a < 16; a++) rd("R1 reset read", 4'(a));
    check("R1 irq at reset", {31'd0, irq}, 0);
    idle(5);
    rd("R2 hold while stopped", 4'd0);
    // R3 half writes near the wrap point, stopped
    wr(4'd0, 32'hFFFF_FFF8);
    rd("R4 flag not yet set", 4'd2);
    rd("R4 flag set one cycle after", 4'd2);
    wr(4'd1, 32'hFFFF_FFFF);
    rd("R3 high half", 4'd1);
    rd("R3 low half kept", 4'd0);
    rd("R4 both count flags", 4'd2);
    // R6 clear one bit, then write 1 to a clear bit
    wr(4'd2, 32'h1);
    rd("R6 clear bit0 only", 4'd2);
    wr(4'd2, 32'h1);
    rd("R6 clear of clear bit", 4'd2);
    wr(4'd2, 32'h2);
    // R2 run across the 2^64 wrap
    wr(4'd6, 32'h1);
    for (int i = 0; i < 12; i++) begin
      rd("R2 count low", 4'd0);
      rd("R2 count high wrap", 4'd1);
    end
    rd("R5 control flag", 4'd9);
    // R6 writes that set no flag
    wr(4'd7, 32'h1);
    wr(4'd8, 32'h0);
    wr(4'd12, 32'hFFFF_FFFF);
    idle(2);
    rd("R6 no flag from enable/status/unmapped", 4'd9);
    rd("R6 unmapped read", 4'd12);
    wr(4'd9, 32'hF);
    rd("R6 general flags cleared", 4'd9);
    // R7 one-shot match
    wr(4'd4, m_cnt[63:32]);
    lo = m_cnt[31:0] + 32'd30;
    wr(4'd3, lo);
    rd("R5 compare flags", 4'd9);
    wr(4'd6, 32'h3);
    idle(40);
    rd("R7 pending after match", 4'd8);
    rd("R7 compare kept", 4'd3);
    wr(4'd8, 32'h1);
    rd("R10 pending cleared", 4'd8);
    // R9/R10 with interrupt disabled
    wr(4'd7, 32'h0);
    lo = m_cnt[31:0] + 32'd10;
    wr(4'd3, lo);
    idle(30);
    rd("R10 pending held with enable off", 4'd8);
    wr(4'd7, 32'h1);
    idle(5);
    rd("R10 pending still held", 4'd8);
    wr(4'd8, 32'h1);
    // R8 periodic mode
    wr(4'd5, 32'd7);
    rd("R5 step read", 4'd5);
    lo = m_cnt[31:0] + 32'd8;
    wr(4'd3, lo);
    wr(4'd6, 32'h7);
    for (int i = 0; i < 60; i++) wr(4'd8, 32'h1);
    rd("R8 compare advanced", 4'd3);
    rd("R8 compare high", 4'd4);
    rd("R8 count", 4'd0);
    done = 1;
    summary();
  end
endmodule